// File: doc/BRIEF.md
# Programmable-Length Circular Event Scheduler

The block keeps a table of transmit events arranged as a ring of frame slots. Each slot holds a fixed number of 32-bit event entries. Software fills the entries through a write port and chooses how many slots the ring uses. Because software picks the slots, it can spread the events of each channel evenly in time. A ring length that is not a power of two lets a cell period that is not a whole number of frames repeat exactly. For example, a period of 46.875 frames repeats exactly over a 375-frame ring.

Each frame tick moves the block to the next slot. It then presents that slot's valid entries, one at a time, on a valid/ready stream. When every valid entry of the slot has been taken, the block raises a one-cycle completion pulse.

If a tick arrives while entries of the current slot are still waiting, the block raises an error pulse. It drops the remaining entries of that slot and goes on with the next slot.

Entry layout:
- bit 31: valid
- bit 30: pointer-byte marker
- bits 11:0: channel index

Only the valid bit changes what the block does. The other bits pass through unchanged.

Top module: `evt_ring_sched`

## Requirements
- R1: While reset is asserted and after it is released, `evt_valid`, `frame_done` and `late_err` are 0, and every stored entry reads as not valid (bit 31 = 0).
- R2: The first `frame_tick` after reset selects slot 0. Each later tick selects the slot one higher, or slot 0 when the current slot is the last one of the active length. `evt_slot` shows the selected slot and changes only on a tick.
- R3: A length written through `len_we`/`len_wdata` becomes the active length only when the ring next returns to slot 0. Until then the old length governs the wrap. After reset both the active and the pending length equal `SLOTS`.
- R4: A written length of 0 acts as 1. A written length above `SLOTS` acts as `SLOTS`.
- R5: Within a slot, only entries with bit 31 set are presented. They come in ascending entry index, carrying exactly the 32-bit word last written to that slot and index.
- R6: While `evt_valid` is high and `evt_ready` is low, `evt_valid` and `evt_data` hold steady until the next tick.
- R7: `frame_done` is high for exactly one cycle, in the cycle after the last valid entry of the slot is accepted, or in the cycle after the tick if the slot has no valid entry. It is never high while `evt_valid` is high.
- R8: A tick that arrives while valid entries of the current slot remain unaccepted raises `late_err` in that same cycle. The remaining entries are dropped, the next slot is scanned from its first entry, and no `frame_done` is given for the dropped slot.
- R9: A write stores `wr_data` at (`wr_slot`, `wr_idx`). Rewriting an entry with bit 31 = 0 removes it from every later scan of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_slot | input | $clog2(SLOTS) | Slot addressed by the write |
| wr_idx | input | IDX_W | Entry index within the slot |
| wr_data | input | 32 | Entry word to store |
| len_we | input | 1 | Ring length write strobe |
| len_wdata | input | $clog2(SLOTS+1) | Requested ring length in slots |
| frame_tick | input | 1 | One-cycle frame start pulse |
| evt_ready | input | 1 | Consumer accepts the presented entry |
| evt_valid | output | 1 | An entry is presented |
| evt_data | output | 32 | Presented entry word |
| evt_slot | output | $clog2(SLOTS) | Slot currently selected |
| frame_done | output | 1 | All entries of the slot handled |
| late_err | output | 1 | Tick arrived before the slot finished |

## Verification
The bench builds the block with `SLOTS = 8` and `IDX_W = 2`, which gives four entries per slot. The whole table, 32 entries, is written with a mix of empty, sparse and full slots. Every slot is visited across several wraps, with three different ready patterns.

This small size makes it cheap to do the following:
- try lengths of 3, 0 and an over-range 15, each crossing a wrap;
- rewrite an entry to remove it;
- force a late tick against a full slot.

A bench-side ring model predicts every slot and entry word.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;

  localparam int VLD_BIT = 31;

  // Length actually used for a requested length.
  function automatic int unsigned clamp_len(int unsigned v, int unsigned maxv);
    if (v == 0) return 1;
    if (v > maxv) return maxv;
    return v;
  endfunction

  // Slot chosen by a tick.
  function automatic int unsigned step_slot(int unsigned cur, int unsigned len, bit started);
    if (!started) return 0;
    if (cur + 1 >= len) return 0;
    return cur + 1;
  endfunction

  // Bits of m at positions from 'from' upward.
  function automatic logic [63:0] mask_from(logic [63:0] m, int unsigned from);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = m[i] & (i >= int'(from));
    return r;
  endfunction

  // Lowest set bit, or 64 if none.
  function automatic int unsigned first_set(logic [63:0] m);
    int unsigned r;
    r = 64;
    for (int i = 63; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/evt_store.sv
module evt_store
  import evt_sched_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int IDX_W = 5,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int EPS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [EPS-1:0]    rd_mask,
  output logic [31:0]       rd_word
);

  logic [30:0]    body [SLOTS*EPS];
  logic [EPS-1:0] vld  [SLOTS];
  logic           wr_hit;

  assign wr_hit = wr_en && ({1'b0, wr_slot} < (SLOT_W+1)'(SLOTS));

  always_ff @(posedge clk) begin
    if (wr_hit) body[{wr_slot, wr_idx}] <= wr_data[30:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) vld[s] <= '0;
    end else if (wr_hit) begin
      vld[wr_slot][wr_idx] <= wr_data[VLD_BIT];
    end
  end

  assign rd_mask = vld[rd_slot];
  assign rd_word = {vld[rd_slot][rd_idx], body[{rd_slot, rd_idx}]};

endmodule

// File: rtl/evt_slot_ptr.sv
module evt_slot_ptr
  import evt_sched_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LEN_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              adv,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              wrap_evt
);

  logic              started;
  logic [SLOT_W-1:0] cur;
  logic [SLOT_W-1:0] nxt;
  logic [LEN_W-1:0]  act_len;
  logic [LEN_W-1:0]  pend_len;

  always_comb begin
    nxt      = SLOT_W'(step_slot(32'(cur), 32'(act_len), started));
    wrap_evt = adv && (nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      cur      <= '0;
      act_len  <= LEN_W'(SLOTS);
      pend_len <= LEN_W'(SLOTS);
    end else begin
      if (len_we) pend_len <= len_wdata;
      if (adv) begin
        started <= 1'b1;
        cur     <= nxt;
        if (wrap_evt) act_len <= LEN_W'(clamp_len(32'(pend_len), SLOTS));
      end
    end
  end

  assign cur_slot = cur;

endmodule

// File: rtl/evt_scan.sv
module evt_scan
  import evt_sched_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int EPS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EPS-1:0]   mask,
  input  logic             ready,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic             done,
  output logic             late
);

  logic           busy;
  logic [IDX_W:0] base;
  logic [EPS-1:0] rem;
  int unsigned    first_i;
  logic           has;
  logic           accept;

  always_comb begin
    rem       = EPS'(mask_from(64'(mask), 32'(base)));
    first_i   = first_set(64'(rem));
    has       = busy && (rem != '0);
    out_valid = has && !start;
    accept    = out_valid && ready;
    done      = busy && (rem == '0);
    late      = start && has;
    out_idx   = IDX_W'(first_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      base <= '0;
    end else if (start) begin
      busy <= 1'b1;
      base <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (accept) begin
      base <= (IDX_W+1)'(first_i + 1);
    end
  end

endmodule

// File: rtl/evt_ring_sched.sv
module evt_ring_sched #(
  parameter int SLOTS = 64,
  parameter int IDX_W = 5,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LEN_W = $clog2(SLOTS + 1),
  localparam int EPS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              frame_tick,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic [31:0]       evt_data,
  output logic [SLOT_W-1:0] evt_slot,
  output logic              frame_done,
  output logic              late_err
);

  logic [SLOT_W-1:0] cur_slot;
  logic              wrap_evt;
  logic [EPS-1:0]    slot_mask;
  logic [IDX_W-1:0]  pick_idx;
  logic [31:0]       word;
  logic              scan_done;
  logic              scan_late;

  evt_slot_ptr #(.SLOTS(SLOTS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_wdata(len_wdata),
    .adv(frame_tick), .cur_slot(cur_slot), .wrap_evt(wrap_evt)
  );

  evt_store #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_slot(cur_slot),
    .rd_idx(pick_idx), .rd_mask(slot_mask), .rd_word(word)
  );

  evt_scan #(.IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(frame_tick), .mask(slot_mask),
    .ready(evt_ready), .out_valid(evt_valid), .out_idx(pick_idx),
    .done(scan_done), .late(scan_late)
  );

  assign evt_data   = word;
  assign evt_slot   = cur_slot;
  assign frame_done = scan_done;
  assign late_err   = scan_late;

endmodule

// File: rtl/evt_ring_sched_chk.sv
module evt_ring_sched_chk #(
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              wr_en,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [31:0]       evt_data,
  input logic [SLOT_W-1:0] evt_slot,
  input logic              frame_done,
  input logic              late_err,
  input logic              wrap_evt
);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (evt_slot == '0) || (evt_slot == $past(evt_slot) + 1'b1));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(evt_slot));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> evt_slot == '0);

  // R5
  only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_data[31]);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && !frame_tick && !wr_en) |=>
      (frame_tick || (evt_valid && $stable(evt_data))));

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !evt_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_tick) |=> !frame_done);

  // R8
  late_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |-> frame_tick && !frame_done);

endmodule

bind evt_ring_sched evt_ring_sched_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wr_en(wr_en),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data),
  .evt_slot(evt_slot), .frame_done(frame_done), .late_err(late_err),
  .wrap_evt(wrap_evt)
);

// File: tb/evt_ring_sched_bench.sv
module evt_ring_sched_bench;
  localparam int SLOTS = 8;
  localparam int IDX_W = 2;
  localparam int EPS = 4;
  localparam int SW = 3;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_slot = '0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic len_we = 1'b0;
  logic [LW-1:0] len_wdata = '0;
  logic frame_tick = 1'b0;
  logic evt_ready = 1'b0;
  logic evt_valid;
  logic [31:0] evt_data;
  logic [SW-1:0] evt_slot;
  logic frame_done;
  logic late_err;

  evt_ring_sched #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_evt_ring_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .wr_data(wr_data), .len_we(len_we), .len_wdata(len_wdata),
    .frame_tick(frame_tick), .evt_ready(evt_ready), .evt_valid(evt_valid),
    .evt_data(evt_data), .evt_slot(evt_slot), .frame_done(frame_done),
    .late_err(late_err)
  );

  always #5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] m_mem [SLOTS][EPS];
  int m_cur = 0;
  bit m_started = 0;
  int m_act = SLOTS;
  int m_pend = SLOTS;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int clampv(int v);
    if (v == 0) return 1;
    if (v > SLOTS) return SLOTS;
    return v;
  endfunction

  function automatic int m_next();
    if (!m_started) return 0;
    return (m_cur + 1 >= m_act) ? 0 : m_cur + 1;
  endfunction

  function automatic logic [31:0] mk(bit v, int s, int i, int g);
    return {v, (i == 0), 18'h0, 12'(s * 16 + i + g * 256)};
  endfunction

  task automatic wr(int s, int i, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(s); wr_idx = IDX_W'(i); wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
    m_mem[s][i] = d;
  endtask

  task automatic wr_len(int v);
    @(negedge clk);
    len_we = 1'b1; len_wdata = LW'(v);
    @(posedge clk); #1 len_we = 1'b0;
    m_pend = v;
  endtask

  task automatic tick(bit exp_late);
    int nx;
    @(negedge clk);
    frame_tick = 1'b1; evt_ready = 1'b0;
    #1 chk(late_err == exp_late, "R8", "late_err at tick", 32'(late_err), 32'(exp_late));
    @(posedge clk); #1 frame_tick = 1'b0;
    nx = m_next();
    m_started = 1; m_cur = nx;
    if (nx == 0) m_act = clampv(m_pend);
  endtask

  task automatic collect(int mode, string tag);
    logic [31:0] el [EPS];
    int cnt = 0, n = 0, gap = 0;
    bit seen = 0, stall = 0, rdy;
    logic [31:0] sdata = '0;
    for (int i = 0; i < EPS; i++) if (m_mem[m_cur][i][31]) begin el[cnt] = m_mem[m_cur][i]; cnt++; end
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      gap++;
      if (frame_done) begin
        chk(n == cnt, "R7", "entries before done", 32'(n), 32'(cnt));
        chk(gap == 1, "R7", "done latency", 32'(gap), 32'd1);
        seen = 1;
        break;
      end
      if (stall) begin
        chk(evt_valid == 1'b1, "R6", "valid held", 32'(evt_valid), 32'd1);
        chk(evt_data == sdata, "R6", "data held", evt_data, sdata);
      end
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? c[0] : (c > 3);
      evt_ready = rdy;
      if (evt_valid && rdy) begin
        chk(n < cnt && evt_data == el[n < cnt ? n : 0], tag, "entry word", evt_data, el[n < cnt ? n : 0]);
        chk(evt_slot == SW'(m_cur), "R2", "slot", 32'(evt_slot), 32'(m_cur));
        n++;
        gap = 0;
      end
      stall = evt_valid && !rdy;
      sdata = evt_data;
    end
    evt_ready = 1'b0;
    if (!seen) chk(1'b0, "R7", "frame_done missing", 32'd0, 32'd1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int nx;
    for (int s = 0; s < SLOTS; s++) for (int i = 0; i < EPS; i++) m_mem[s][i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(evt_valid == 1'b0, "R1", "evt_valid in reset", 32'(evt_valid), 32'd0);
    chk(frame_done == 1'b0, "R1", "frame_done in reset", 32'(frame_done), 32'd0);
    chk(late_err == 1'b0, "R1", "late_err in reset", 32'(late_err), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    // R1 after release: first slot scan with empty table gives no entries
    tick(0);
    collect(0, "R1");
    // R9 fill table: slot 3 empty, slot 5 full, others sparse
    for (int s = 0; s < SLOTS; s++)
      for (int i = 0; i < EPS; i++)
        wr(s, i, mk((s == 5) ? 1'b1 : (s == 3) ? 1'b0 : ((s + i) % 3 != 1), s, i, 0));
    // R2 / R5 sweep over two wraps with three ready patterns
    for (int f = 0; f < 18; f++) begin tick(0); collect(f % 3, "R5"); end
    // R3 shorter ring takes effect at next wrap
    wr_len(3);
    for (int f = 0; f < 14; f++) begin tick(0); collect(f % 3, "R3"); end
    // R4 zero length acts as one
    wr_len(0);
    for (int f = 0; f < 6; f++) begin tick(0); collect(f % 3, "R4"); end
    // R4 over-range length acts as SLOTS
    wr_len(15);
    for (int f = 0; f < 12; f++) begin tick(0); collect(f % 3, "R4"); end
    // R9 rewrite: drop entry 1, replace entry 2 of the next slot
    nx = m_next();
    wr(nx, 1, mk(1'b0, nx, 1, 1));
    wr(nx, 2, mk(1'b1, nx, 2, 1));
    tick(0);
    collect(1, "R9");
    // R8 late tick against a full slot
    nx = m_next();
    for (int i = 0; i < EPS; i++) wr(nx, i, mk(1'b1, nx, i, 2));
    tick(0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(evt_valid == 1'b1, "R8", "entry pending", 32'(evt_valid), 32'd1);
      chk(frame_done == 1'b0, "R8", "no done while pending", 32'(frame_done), 32'd0);
    end
    tick(1);
    collect(0, "R8");
    for (int f = 0; f < 4; f++) begin tick(0); collect(2, "R5"); end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule